// File: doc/BRIEF.md
# Microcoded Video Timing Waveform Sequencer

This block produces video synchronisation and data-enable waveforms by executing a small stored program. It does not compare free-running counters against thresholds. The program memory holds 14-bit instructions. The engine advances at most one step on each clock where the pixel enable is high. It drives an 8-bit output level, a data-enable bit and a mux-select bit, and holds all three in registers between the steps that change them.

The program uses two loop levels to describe a line and then a frame. An inner loop is marked by a repeat-marker instruction and closed by a repeat instruction. An outer loop is marked by a replay-marker instruction and closed by a replay instruction. Counted skips cover the long stretches inside a line, and the program ends with either a stop or a hold. Software loads the program while the engine is stopped. A one-cycle frame-start pulse then restarts the program from address zero.

Top module: `wave_seq_core`

## Requirements
- R1: An instruction is 14 bits: bits 13:10 are the opcode and bits 9:0 are the argument. The opcode values are SET=0, RPTSET=1, RPLSET=2, SKIP=3, STOP=4, REPEAT=5, REPLAY=6, JUMP=7 and HOLD=8. The engine executes at most one instruction per clock with pix_en high.
- R2: SET, RPTSET, RPLSET and HOLD load the outputs from the argument at the edge where they execute: level_o from bits 7:0, mux_o from bit 8 and de_o from bit 9. Together these ten bits form {de_o, mux_o, level_o}.
- R3: SKIP N (N≥1) occupies N+1 enabled steps, and the outputs do not change during those steps. The next instruction executes on the step after them.
- R4: RPTSET records its own address as the inner marker. REPEAT N branches back to that marker N additional times and then falls through. REPEAT 0 falls through at once. The REPEAT step itself does not change the outputs.
- R5: RPLSET records its own address as the outer marker. REPLAY N branches back to that marker N additional times. An inner loop nested inside the outer loop runs its full count on every outer pass.
- R6: JUMP continues execution at the address in argument bits 5:0.
- R7: STOP halts the engine. The outputs and the program counter stay frozen until the next frame_start.
- R8: HOLD applies its outputs and then stalls the program counter until the next frame_start.
- R9: frame_start, whatever the value of pix_en, clears the program counter and both loop counters and puts the engine into run. It executes no instruction on that edge, and address 0 executes on the next enabled edge.
- R10: While pix_en is low and frame_start is low, the program counter, the loop state and the outputs do not change.
- R11: An opcode value of 9 to 15 acts as STOP and sets err_o. err_o is then cleared only by rst_n.
- R12: A write on prog_we takes effect only while the engine is stopped, either after reset or after a STOP or illegal opcode. A write issued while the engine runs or holds is ignored.
- R13: While rst_n is low, level_o, de_o, mux_o and err_o go to 0 and the engine stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_en | input | 1 | Step enable, one program step per high cycle |
| frame_start | input | 1 | Restart pulse: clears the program counter and loop counters |
| prog_we | input | 1 | Program memory write strobe |
| prog_addr | input | ADDR_W (6) | Program memory write address |
| prog_data | input | 14 | Instruction word to write |
| level_o | output | 8 | Output level |
| de_o | output | 1 | Data-enable waveform |
| mux_o | output | 1 | Mux-select waveform |
| err_o | output | 1 | Sticky flag for an illegal opcode |

## Verification
The hardest case to reach is a restart in the middle of a loop. The outer replay counter has already started counting, and a wrongly kept counter only shows up one full pass later, as a loop that is too short. The stimulus lets a nested repeat/replay program run until the outer replay has begun. It then pulses frame_start in that exact cycle and scores the whole rerun step by step, so a replay that falls through early shows up as a missing line of outputs. The stimulus also writes to memory during a HOLD and then restarts, so that an accepted write would show up in the first step.

// File: rtl/wave_seq_pkg.sv
// Shared encodings for the waveform sequencer.
// Assumes the 14-bit instruction layout {opcode[3:0], arg[9:0]}.
package wave_seq_pkg;

    localparam int OPC_W  = 4;
    localparam int ARG_W  = 10;
    localparam int INSN_W = OPC_W + ARG_W;
    localparam int LVL_W  = 8;

    typedef enum logic [OPC_W-1:0] {
        OP_SET    = 4'd0,
        OP_RPTSET = 4'd1,
        OP_RPLSET = 4'd2,
        OP_SKIP   = 4'd3,
        OP_STOP   = 4'd4,
        OP_REPEAT = 4'd5,
        OP_REPLAY = 4'd6,
        OP_JUMP   = 4'd7,
        OP_HOLD   = 4'd8
    } opcode_e;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_RUN  = 2'd1,
        ST_SKIP = 2'd2,
        ST_HOLD = 2'd3
    } run_state_e;

    // Bit order matches argument bits 9:0 of a drive instruction.
    typedef struct packed {
        logic             de;
        logic             mux;
        logic [LVL_W-1:0] level;
    } drive_t;

endpackage

// File: rtl/wave_seq_mem.sv
// Program store: synchronous write, combinational read.
// Assumes the caller gates writes (the core only writes while stopped).
module wave_seq_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Write one word per strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Fetch the word at the program counter.
    assign rdata = store[raddr];

endmodule

// File: rtl/wave_seq_decode.sv
// Splits an instruction word into opcode, legality, drive fields,
// count and jump target. Purely combinational.
module wave_seq_decode
    import wave_seq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [INSN_W-1:0] insn,
    output opcode_e           op,
    output logic              legal,
    output drive_t            drv,
    output logic [ARG_W-1:0]  count,
    output logic [ADDR_W-1:0] target
);
    // Field extraction.
    always_comb begin
        op     = opcode_e'(insn[INSN_W-1:ARG_W]);
        drv    = drive_t'(insn[ARG_W-1:0]);
        count  = insn[ARG_W-1:0];
        target = insn[ADDR_W-1:0];
    end

    // Opcode values above HOLD are illegal.
    assign legal = (insn[INSN_W-1:ARG_W] <= OPC_W'(OP_HOLD));

endmodule

// File: rtl/wave_seq_loop.sv
// One loop level: holds a marker address and a remaining-branch count.
// The first closing step loads n-1 and branches; later steps count down;
// the closing step falls through when the count is spent.
// Assumes step and mark_we are only raised on executing enabled steps.
module wave_seq_loop #(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              mark_we,
    input  logic [ADDR_W-1:0] mark_addr,
    input  logic              step,
    input  logic [CNT_W-1:0]  n,
    output logic [ADDR_W-1:0] mark,
    output logic              branch
);
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    // Branch decision for the closing instruction seen this step.
    assign branch = busy_q ? (cnt_q != '0) : (n != '0);

    // Marker capture and iteration counting.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            mark   <= '0;
        end else begin
            if (mark_we) begin
                mark <= mark_addr;
            end
            if (step) begin
                if (busy_q) begin
                    if (cnt_q == '0) begin
                        busy_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end else if (n != '0) begin
                    busy_q <= 1'b1;
                    cnt_q  <= n - CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/wave_seq_core.sv
// Waveform sequencer top: program counter, run state, skip counter and
// output registers. Executes one instruction per pix_en cycle.
// Assumes frame_start is a single-cycle pulse; it outranks pix_en.
module wave_seq_core
    import wave_seq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              frame_start,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [INSN_W-1:0] prog_data,
    output logic [LVL_W-1:0]  level_o,
    output logic              de_o,
    output logic              mux_o,
    output logic              err_o
);
    localparam int N_LOOPS = 2;   // 0: inner repeat, 1: outer replay

    run_state_e        state_q;
    logic [ADDR_W-1:0] pc_q;
    logic [ARG_W-1:0]  skip_q;
    drive_t            drv_q;
    logic              err_q;

    logic [INSN_W-1:0] insn;
    opcode_e           op;
    logic              legal;
    drive_t            drv;
    logic [ARG_W-1:0]  count;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] pc_inc;
    logic              exec;

    logic [ADDR_W-1:0] loop_mark   [N_LOOPS];
    logic              loop_branch [N_LOOPS];
    logic              loop_set    [N_LOOPS];
    logic              loop_close  [N_LOOPS];

    // Program store, writable only while stopped.
    wave_seq_mem #(.ADDR_W(ADDR_W), .DATA_W(INSN_W)) i_mem (
        .clk   (clk),
        .we    (prog_we && (state_q == ST_STOP) && !frame_start),
        .waddr (prog_addr),
        .wdata (prog_data),
        .raddr (pc_q),
        .rdata (insn)
    );

    wave_seq_decode #(.ADDR_W(ADDR_W)) i_dec (
        .insn   (insn),
        .op     (op),
        .legal  (legal),
        .drv    (drv),
        .count  (count),
        .target (target)
    );

    // An instruction executes on enabled steps in the run state.
    assign exec   = pix_en && !frame_start && (state_q == ST_RUN);
    assign pc_inc = pc_q + ADDR_W'(1);

    // Per-level marker and closing strobes.
    always_comb begin
        loop_set[0]   = exec && (op == OP_RPTSET);
        loop_close[0] = exec && (op == OP_REPEAT);
        loop_set[1]   = exec && (op == OP_RPLSET);
        loop_close[1] = exec && (op == OP_REPLAY);
    end

    for (genvar g = 0; g < N_LOOPS; g++) begin : g_loop
        wave_seq_loop #(.ADDR_W(ADDR_W), .CNT_W(ARG_W)) i_loop (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (frame_start),
            .mark_we   (loop_set[g]),
            .mark_addr (pc_q),
            .step      (loop_close[g]),
            .n         (count),
            .mark      (loop_mark[g]),
            .branch    (loop_branch[g])
        );
    end

    // Sequencing: restart, execute, count skips, halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
            pc_q    <= '0;
            skip_q  <= '0;
            drv_q   <= '0;
            err_q   <= 1'b0;
        end else if (frame_start) begin
            state_q <= ST_RUN;
            pc_q    <= '0;
            skip_q  <= '0;
        end else if (pix_en) begin
            unique case (state_q)
                ST_RUN: begin
                    if (!legal) begin
                        state_q <= ST_STOP;
                        err_q   <= 1'b1;
                    end else begin
                        case (op)
                            OP_SET, OP_RPTSET, OP_RPLSET: begin
                                drv_q <= drv;
                                pc_q  <= pc_inc;
                            end
                            OP_HOLD: begin
                                drv_q   <= drv;
                                state_q <= ST_HOLD;
                            end
                            OP_SKIP: begin
                                if (count == '0) begin
                                    pc_q <= pc_inc;
                                end else begin
                                    skip_q  <= count;
                                    state_q <= ST_SKIP;
                                end
                            end
                            OP_REPEAT: pc_q <= loop_branch[0] ? loop_mark[0] : pc_inc;
                            OP_REPLAY: pc_q <= loop_branch[1] ? loop_mark[1] : pc_inc;
                            OP_JUMP:   pc_q <= target;
                            default:   state_q <= ST_STOP;
                        endcase
                    end
                end
                ST_SKIP: begin
                    if (skip_q <= ARG_W'(1)) begin
                        pc_q    <= pc_inc;
                        state_q <= ST_RUN;
                    end else begin
                        skip_q <= skip_q - ARG_W'(1);
                    end
                end
                default: begin
                    state_q <= state_q;
                end
            endcase
        end
    end

    // Registered outputs.
    assign level_o = drv_q.level;
    assign de_o    = drv_q.de;
    assign mux_o   = drv_q.mux;
    assign err_o   = err_q;

endmodule

// File: rtl/wave_seq_chk.sv
// Protocol checker for wave_seq_core, attached by bind below.
// Observes ports plus the run state and program counter.
module wave_seq_chk
    import wave_seq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_en,
    input logic              frame_start,
    input logic [LVL_W-1:0]  level_o,
    input logic              de_o,
    input logic              mux_o,
    input logic              err_o,
    input run_state_e        state_q,
    input logic [ADDR_W-1:0] pc_q
);
    logic [LVL_W+1:0] outs;
    assign outs = {de_o, mux_o, level_o};

    // R13: reset forces outputs low and stops the engine.
    a_r13_reset_state: assert property (@(posedge clk)
        !rst_n |=> (outs == '0) && !err_o && (state_q == ST_STOP));

    // R3: outputs do not move while a skip is being counted.
    a_r3_skip_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !frame_start && state_q == ST_SKIP) |=> $stable(outs));

    // R7: a stopped engine stays put.
    a_r7_stop_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !frame_start)
        |=> $stable(outs) && $stable(pc_q) && state_q == ST_STOP);

    // R8: a held engine stays put until restart.
    a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !frame_start)
        |=> $stable(outs) && $stable(pc_q) && state_q == ST_HOLD);

    // R9: restart lands at address zero in run.
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (pc_q == '0) && (state_q == ST_RUN));

    // R10: no progress without the pixel enable.
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_en && !frame_start)
        |=> $stable(pc_q) && $stable(state_q) && $stable(outs));

    // R11: the error flag is sticky.
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

endmodule

bind wave_seq_core wave_seq_chk #(.ADDR_W(ADDR_W)) i_wave_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_en      (pix_en),
    .frame_start (frame_start),
    .level_o     (level_o),
    .de_o        (de_o),
    .mux_o       (mux_o),
    .err_o       (err_o),
    .state_q     (state_q),
    .pc_q        (pc_q)
);

// File: tb/test_wave_seq_core.sv
// Scoreboard bench: driver tasks queue expected {de,mux,level} per step,
// a monitor pops one item 1 time unit after every rising edge.
module test_wave_seq_core;

    localparam int ADDR_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pix_en = 1'b1;
    logic              frame_start = 1'b0;
    logic              prog_we = 1'b0;
    logic [ADDR_W-1:0] prog_addr = '0;
    logic [13:0]       prog_data = '0;
    logic [7:0]        level_o;
    logic              de_o;
    logic              mux_o;
    logic              err_o;

    int n_vec = 0;
    int n_err = 0;
    bit done  = 0;

    logic [9:0] exp_q [$];
    string      tag_q [$];
    logic [9:0] exp_v;
    string      exp_t;

    // 250 MHz: 4 time-unit period.
    always #2 clk = ~clk;

    wave_seq_core #(.ADDR_W(ADDR_W)) i_wave_seq_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_en      (pix_en),
        .frame_start (frame_start),
        .prog_we     (prog_we),
        .prog_addr   (prog_addr),
        .prog_data   (prog_data),
        .level_o     (level_o),
        .de_o        (de_o),
        .mux_o       (mux_o),
        .err_o       (err_o)
    );

    // Opcode values from R1.
    localparam logic [3:0] SET = 0, RPTSET = 1, RPLSET = 2, SKIP = 3, STOP = 4,
                           REPEAT = 5, REPLAY = 6, JUMP = 7, HOLD = 8, BAD = 9;

    function automatic logic [13:0] ins(input logic [3:0] op, input logic [9:0] a);
        return {op, a};
    endfunction

    task automatic push(input logic [9:0] v, input int n, input string t);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(v);
            tag_q.push_back(t);
        end
    endtask

    task automatic check(input string t, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", t, got, exp);
        end
    endtask

    task automatic load(input int a, input logic [13:0] d);
        @(negedge clk);
        prog_we   = 1'b1;
        prog_addr = ADDR_W'(a);
        prog_data = d;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
    endtask

    // Monitor: compare one expected item per edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_v = exp_q.pop_front();
            exp_t = tag_q.pop_front();
            n_vec++;
            if ({de_o, mux_o, level_o} !== exp_v) begin
                n_err++;
                $display("FAIL %s: got %h expected %h", exp_t, {de_o, mux_o, level_o}, exp_v);
            end
        end
    end

    task automatic push_prog_a();
        push(10'h211, 5, "R2/R3 set then skip 3");
        push(10'h122, 2, "R2/R6 set then jump");
        push(10'h033, 4, "R6/R7 jump target then stop");
    endtask

    task automatic push_prog_b();
        push(10'h001, 1, "R5 replay marker");
        push(10'h202, 4, "R4 inner repeat 1");
        push(10'h003, 2, "R5 set then replay");
        push(10'h001, 1, "R5 outer pass 2");
        push(10'h202, 4, "R5 inner loop rerun");
        push(10'h003, 4, "R5 fall through to stop");
    endtask

    task automatic push_prog_c();
        push(10'h044, 2, "R4 repeat 0 falls through");
        push(10'h155, 4, "R8 hold");
    endtask

    initial begin
        // R13: reset state.
        repeat (3) @(negedge clk);
        check("R13 outputs in reset", {22'd0, de_o, mux_o, level_o}, 32'd0);
        check("R13 err in reset", {31'd0, err_o}, 32'd0);
        rst_n = 1'b1;

        // Program A: set, skip, jump, stop (R1 R2 R3 R6 R7 R12).
        load(0, ins(SET, 10'h211));
        load(1, ins(SKIP, 10'd3));
        load(2, ins(SET, 10'h122));
        load(3, ins(JUMP, 10'h045));
        load(4, ins(SET, 10'h3FF));
        load(5, ins(SET, 10'h033));
        load(6, ins(STOP, 10'd0));
        pulse_start();
        push_prog_a();
        drain();

        // R10: three disabled edges after restart, then run program A again.
        pulse_start();
        pix_en = 1'b0;
        push(10'h033, 3, "R10 no step while pix_en low");
        push_prog_a();
        repeat (3) @(negedge clk);
        pix_en = 1'b1;
        drain();

        // Program B: nested repeat inside replay (R4 R5).
        load(0, ins(RPLSET, 10'h001));
        load(1, ins(RPTSET, 10'h202));
        load(2, ins(REPEAT, 10'd1));
        load(3, ins(SET, 10'h003));
        load(4, ins(REPLAY, 10'd1));
        load(5, ins(STOP, 10'd0));
        pulse_start();
        push(10'h001, 1, "R5 replay marker");
        push(10'h202, 4, "R4 inner repeat 1");
        push(10'h003, 2, "R5 set then replay");
        push(10'h001, 1, "R5 outer pass 2");
        push(10'h202, 1, "R5 outer pass 2 inner marker");
        drain();
        // R9: restart mid-loop; counters must be cleared for a full rerun.
        pulse_start();
        push_prog_b();
        drain();

        // Program C: repeat 0, hold (R4 R8), write during hold ignored (R12).
        load(0, ins(RPTSET, 10'h044));
        load(1, ins(REPEAT, 10'd0));
        load(2, ins(HOLD, 10'h155));
        load(3, ins(SET, 10'h066));
        pulse_start();
        push_prog_c();
        drain();
        load(0, ins(SET, 10'h3AA));
        pulse_start();
        push(10'h044, 1, "R12 write during hold ignored");
        push(10'h044, 1, "R4 repeat 0 falls through");
        push(10'h155, 4, "R8 hold after restart");
        drain();

        // Program D: illegal opcode (R11).
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R13 err cleared by reset", {31'd0, err_o}, 32'd0);
        rst_n = 1'b1;
        load(0, ins(SET, 10'h077));
        load(1, ins(BAD, 10'h3FF));
        load(2, ins(SET, 10'h088));
        pulse_start();
        push(10'h077, 4, "R11 illegal opcode acts as stop");
        drain();
        check("R11 err raised", {31'd0, err_o}, 32'd1);
        pulse_start();
        @(negedge clk);
        check("R11 err sticky over restart", {31'd0, err_o}, 32'd1);
        push(10'h077, 3, "R11 rerun stops again");
        drain();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 err cleared only by reset", {31'd0, err_o}, 32'd0);
        check("R13 outputs after reset", {22'd0, de_o, mux_o, level_o}, 32'd0);
        rst_n = 1'b1;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #800000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

endmodule